// File: doc/BRIEF.md
# MDIO Station Management Master

This block lets a host run single management transactions against an external PHY over the two-wire MDC/MDIO bus. The host programs a 12-bit command word carrying the target PHY address, the target register address, a direction bit and a start/busy bit. It also uses a 16-bit data word. For a write, the data word is loaded first. For a read, the data word returns the PHY's reply once the transaction has finished.

The block drives MDC only while a transaction is in flight. MDC comes from the system clock through a divider input `mdcDiv`. Each MDC half period lasts `mdcDiv+1` system clocks, so fMDC = fclk / (2·(mdcDiv+1)). To reach a wanted MDC rate, program `mdcDiv = fclk/fMDC/2 − 1` (for example 2.5 MHz). Each frame is 64 MDC cycles long and is sent MSB first: 32 preamble ones, start `01`, opcode, PHY address, register address, turnaround, then 16 data bits. The master changes MDIO only on MDC falling edges and samples read data at MDC rising edges.

The start bit reads back as the busy flag. While busy is high, the block refuses every host write to either word.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the status word reads 0, the data word reads 0, `mdc` is low and `mdioOe` is low.
- R2: The command word layout is: bits [4:0] register address, [9:5] PHY address, bit 10 direction (1 = write, 0 = read), bit 11 start. A command write with bit 11 set while idle makes status bit 11 (busy) read 1 from the next cycle. Busy stays 1 for exactly 128·(mdcDiv+1) clock cycles and then reads 0.
- R3: During a transaction each MDC level lasts `mdcDiv+1` clock cycles and one frame holds exactly 64 MDC rising edges. While idle, `mdc` is low.
- R4: At the n-th MDC rising edge (n = 0..63), `mdioO` carries frame bit n: bits 0..31 are 1; bits 32..33 are `0,1`; bits 34..35 are `1,0` for a read and `0,1` for a write; bits 36..40 are the PHY address MSB first; bits 41..45 are the register address MSB first.
- R5: In a write frame, bits 46..47 are `1,0`, bits 48..63 are the data word MSB first, and `mdioOe` is high at all 64 rising edges. Afterwards the data word is unchanged.
- R6: In a read frame, `mdioOe` is high at rising edges 0..45 and low at 46..63. The value on `mdioI` in the clock cycle just before rising edges 48..63 forms the 16-bit reply, MSB first, and the data word holds this reply once busy clears.
- R7: While busy, command writes and data writes are ignored. The frame in flight, the status fields and the final data word are unaffected.
- R8: `mdioO` does not change in the clock cycle in which `mdc` rises.
- R9: A command write with bit 11 clear while idle stores the direction, PHY and register fields into the status word without starting a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mdcDiv | input | DIV_W | MDC divider; half period = mdcDiv+1 clocks |
| cmdWr | input | 1 | Write strobe for the command word |
| cmdData | input | 12 | Command word: start, direction, PHY address, register address |
| datWr | input | 1 | Write strobe for the data word |
| datIn | input | 16 | Data word write value |
| cmdStatus | output | 12 | Readback: busy, direction, PHY address, register address |
| datOut | output | 16 | Data word: write data, or read reply |
| mdc | output | 1 | Management clock to the PHY |
| mdioO | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioI | input | 1 | MDIO input from the pad |

## Verification
The bench keeps the default 8-bit divider width but drives `mdcDiv` through 0, 1, 2, 3 and 7. Short divider values keep each frame to a few hundred cycles, so every bit position of many whole frames can be compared against an arithmetically built frame. The divider range covers the zero-divider case, where MDC toggles every clock and the sample and shift strobes sit on adjacent cycles. At each setting the bench runs write and read frames with all-ones, alternating and single-bit patterns, and injects writes while busy. It also checks the length of every MDC half period and the exact busy duration.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DAT_W     = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DAT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int FIELD_W   = PHY_W + REG_W + 1;
  localparam int CMD_W     = FIELD_W + 1;
  localparam int TA_POS    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int RD_POS    = TA_POS + 2;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
  } mdioStrobeT;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap     = (cnt >= div);
  assign riseTick = en && wrap && !mdc;
  assign fallTick = en && wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: clock parks low whenever no transaction runs
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !mdc && (cnt == '0));
  // R3: a tick of each kind never coincides
  a_r3_tick_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(riseTick && fallTick));
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       opWrite,
  input  logic       riseTick,
  input  logic       fallTick,
  output logic       busy,
  output logic       mdioOe,
  output mdioStrobeT strb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_BIT   = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] RD_BIT   = CNT_W'(RD_POS);

  logic [CNT_W-1:0] bitIdx;
  logic             isRead;
  logic             finish;

  always_comb begin
    strb.load   = startReq && !busy;
    strb.shift  = busy && fallTick;
    strb.sample = busy && riseTick && isRead && (bitIdx >= RD_BIT);
    finish      = strb.shift && (bitIdx == LAST_BIT);
    mdioOe      = busy && !(isRead && (bitIdx >= TA_BIT));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
      isRead <= 1'b0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      bitIdx <= '0;
      isRead <= !opWrite;
    end else if (strb.shift) begin
      bitIdx <= bitIdx + 1'b1;
      if (finish) busy <= 1'b0;
    end
  end

  // R2: a start while idle raises busy with the bit counter at zero
  a_r2_launch: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !busy |=> busy && (bitIdx == '0));
  // R2: the last falling edge ends the transaction
  a_r2_clear_at_end: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !busy);
  // R6: read data is only taken while the master has released the line
  a_r6_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> !mdioOe);
  // R7: strobes to the datapath are mutually exclusive
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.sample}));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busy,
  input  logic               cmdWr,
  input  logic [FIELD_W-1:0] cmdFields,
  input  logic               datWr,
  input  logic [DAT_W-1:0]   datIn,
  input  mdioStrobeT         strb,
  input  logic               mdioI,
  output logic [FIELD_W-1:0] fieldsOut,
  output logic [DAT_W-1:0]   datOut,
  output logic               mdioO
);
  logic [PHY_W-1:0]     phyReg;
  logic [REG_W-1:0]     regReg;
  logic                 opReg;
  logic [DAT_W-1:0]     datReg;
  logic [FRAME_LEN-1:0] frameSr;
  logic [FRAME_LEN-1:0] frameNew;
  logic                 newWrite;

  assign newWrite = cmdFields[FIELD_W-1];

  always_comb begin
    frameNew = {{PRE_LEN{1'b1}}, 2'b01,
                (newWrite ? 2'b01 : 2'b10),
                cmdFields[REG_W +: PHY_W],
                cmdFields[0 +: REG_W],
                2'b10,
                (newWrite ? datReg : {DAT_W{1'b1}})};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyReg <= '0;
      regReg <= '0;
      opReg  <= 1'b0;
    end else if (cmdWr && !busy) begin
      opReg  <= newWrite;
      phyReg <= cmdFields[REG_W +: PHY_W];
      regReg <= cmdFields[0 +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      datReg <= '0;
    end else if (datWr && !busy) begin
      datReg <= datIn;
    end else if (strb.sample) begin
      datReg <= {datReg[DAT_W-2:0], mdioI};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '0;
    end else if (strb.load) begin
      frameSr <= frameNew;
    end else if (strb.shift) begin
      frameSr <= {frameSr[FRAME_LEN-2:0], 1'b1};
    end
  end

  assign mdioO     = frameSr[FRAME_LEN-1];
  assign fieldsOut = {opReg, phyReg, regReg};
  assign datOut    = datReg;

  // R7: host writes cannot disturb the data word mid-transaction
  a_r7_data_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strb.sample |=> $stable(datReg));
  // R7: stored fields hold while busy
  a_r7_fields_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({opReg, phyReg, regReg}));
  // R8: the frame only moves on a load or a falling-edge shift
  a_r8_shift_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift && !strb.load |=> $stable(frameSr));
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] mdcDiv,
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             datWr,
  input  logic [DAT_W-1:0] datIn,
  output logic [CMD_W-1:0] cmdStatus,
  output logic [DAT_W-1:0] datOut,
  output logic             mdc,
  output logic             mdioO,
  output logic             mdioOe,
  input  logic             mdioI
);
  logic               busy;
  logic               riseTick;
  logic               fallTick;
  logic [FIELD_W-1:0] fieldsOut;
  mdioStrobeT         strb;

  mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk      (clk),
    .rstN     (rstN),
    .en       (busy),
    .div      (mdcDiv),
    .mdc      (mdc),
    .riseTick (riseTick),
    .fallTick (fallTick)
  );

  mdio_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (cmdWr && cmdData[CMD_W-1]),
    .opWrite  (cmdData[CMD_W-2]),
    .riseTick (riseTick),
    .fallTick (fallTick),
    .busy     (busy),
    .mdioOe   (mdioOe),
    .strb     (strb)
  );

  mdio_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .busy      (busy),
    .cmdWr     (cmdWr),
    .cmdFields (cmdData[FIELD_W-1:0]),
    .datWr     (datWr),
    .datIn     (datIn),
    .strb      (strb),
    .mdioI     (mdioI),
    .fieldsOut (fieldsOut),
    .datOut    (datOut),
    .mdioO     (mdioO)
  );

  assign cmdStatus = {busy, fieldsOut};

  // R8: line value is settled when the PHY samples it
  a_r8_mdio_steady: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> $stable(mdioO));
endmodule

// File: tb/test_mdio_mgmt.sv
`timescale 1ns/1ps
module test_mdio_mgmt;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [DIV_W-1:0] mdcDiv = '0;
  logic             cmdWr = 1'b0;
  logic [11:0]      cmdData = '0;
  logic             datWr = 1'b0;
  logic [15:0]      datIn = '0;
  logic [11:0]      cmdStatus;
  logic [15:0]      datOut;
  logic             mdc, mdioO, mdioOe, mdioI;

  int nChecks = 0;
  int nErrors = 0;
  int curDiv = 0;
  logic [15:0] curReply = '0;
  int riseCnt = 0, riseBase = 0, busyCnt = 0, halfErr = 0, lenCnt = 0;
  bit haveEdge = 0;
  logic prevMdc = 1'b0;
  logic txBit [64];
  logic oeBit [64];

  always #2 clk = ~clk;

  mdio_mgmt #(.DIV_W(DIV_W)) i_mdio_mgmt (
    .clk(clk), .rstN(rstN), .mdcDiv(mdcDiv), .cmdWr(cmdWr), .cmdData(cmdData),
    .datWr(datWr), .datIn(datIn), .cmdStatus(cmdStatus), .datOut(datOut),
    .mdc(mdc), .mdioO(mdioO), .mdioOe(mdioOe), .mdioI(mdioI)
  );

  // PHY model reply: bit for rising edge n (48..63) is reply[63-n]
  assign mdioI = ((riseCnt - riseBase) >= 48 && (riseCnt - riseBase) < 64)
                 ? curReply[63 - (riseCnt - riseBase)] : 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (cmdStatus[11]) busyCnt++;
      if (mdc !== prevMdc) begin
        if (haveEdge && lenCnt != curDiv + 1) halfErr++;
        if (mdc) begin
          if ((riseCnt - riseBase) < 64) begin
            txBit[riseCnt - riseBase] = mdioO;
            oeBit[riseCnt - riseBase] = mdioOe;
          end
          riseCnt++;
        end
        lenCnt = 1;
        haveEdge = 1;
      end else begin
        lenCnt++;
      end
      if (!cmdStatus[11]) haveEdge = 0;
      prevMdc = mdc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expBit(input int i, input bit wr, input logic [4:0] phy,
                                  input logic [4:0] rg, input logic [15:0] w);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, w};
    return f[63 - i];
  endfunction

  task automatic runTxn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] word, input bit intrude);
    int b0, h0, guard, mism, oeMis;
    string tag;
    if (wr) begin
      @(negedge clk); datWr = 1'b1; datIn = word;
      @(negedge clk); datWr = 1'b0;
    end
    curReply = word;
    riseBase = riseCnt;
    b0 = busyCnt;
    h0 = halfErr;
    @(negedge clk); cmdWr = 1'b1; cmdData = {1'b1, wr, phy, rg};
    @(negedge clk); cmdWr = 1'b0;
    chk("R2 busy after start", int'(cmdStatus[11]), 1);
    if (intrude) begin
      repeat (7) @(negedge clk);
      cmdWr = 1'b1; cmdData = {1'b1, ~wr, ~phy, ~rg};
      datWr = 1'b1; datIn = ~word;
      @(negedge clk); cmdWr = 1'b0; datWr = 1'b0;
    end
    guard = 0;
    while (cmdStatus[11] && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    #1;
    chk("R2 busy duration", busyCnt - b0, 128 * (curDiv + 1));
    chk("R3 half period", halfErr - h0, 0);
    chk("R3 rising edges per frame", riseCnt - riseBase, 64);
    mism = 0;
    oeMis = 0;
    for (int i = 0; i < 64; i++) begin
      if (wr || i < 46)
        if (txBit[i] !== expBit(i, wr, phy, rg, word)) mism++;
      if (oeBit[i] !== ((wr || i < 46) ? 1'b1 : 1'b0)) oeMis++;
    end
    chk("R4 frame bit mismatches", mism, 0);
    chk(wr ? "R5 output enable" : "R6 output enable", oeMis, 0);
    tag = intrude ? "R7 data word" : (wr ? "R5 data word" : "R6 read reply");
    chk(tag, int'(datOut), int'(word));
    chk(intrude ? "R7 status fields" : "R2 status after end",
        int'(cmdStatus), int'({1'b0, wr, phy, rg}));
    chk("R3 idle mdc", int'({mdc, mdioOe}), 0);
  endtask

  initial begin
    #(4 * 150000);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 status reset", int'(cmdStatus), 0);
    chk("R1 data reset", int'(datOut), 0);
    chk("R1 mdc/oe reset", int'({mdc, mdioOe}), 0);

    // R9: fields stored without a launch
    @(negedge clk); cmdWr = 1'b1; cmdData = {1'b0, 1'b1, 5'h1A, 5'h07};
    @(negedge clk); cmdWr = 1'b0;
    chk("R9 stored fields", int'(cmdStatus), int'({1'b0, 1'b1, 5'h1A, 5'h07}));
    repeat (20) @(negedge clk);
    chk("R9 no launch", int'({cmdStatus[11], mdc, mdioOe}), 0);

    foreach (curReply[k]) begin end
    for (int d = 0; d < 5; d++) begin
      curDiv = (d == 4) ? 7 : d;
      mdcDiv = DIV_W'(curDiv);
      runTxn(1'b1, 5'(d + 3), 5'h15, 16'hA5C3 ^ 16'(d * 16'h1111), 1'b0);
      runTxn(1'b0, 5'h0A, 5'(d), 16'h3C5A ^ 16'(d * 16'h0101), 1'b0);
      runTxn(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 1'b1);
      runTxn(1'b0, 5'h00, 5'h00, 16'h8001, 1'b1);
      runTxn(1'b1, 5'h10, 5'h01, 16'h0000, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule